// File: doc/BRIEF.md
# Packed-Lane Video SIMD ALU

This block is an arithmetic unit for pixel processing. It treats each 32-bit operand as a set of independent lanes: four 8-bit lanes or two 16-bit lanes, picked by a mode input. One operation code applies the same function to every lane at once. No carry, borrow or compare result crosses from one lane into another.

The functions are wrapping add and subtract, absolute difference, rounding average, maximum, minimum and a per-lane compare that writes a 0/1 flag. A sign-mode bit chooses two's-complement or unsigned reading of the lanes for the order-sensitive functions. A 3-bit compare selector picks the relation that the compare function tests.

The result is registered once. A command presented at a rising clock edge appears on the output after that edge.

Top module: `pkd_simd_alu`

## Requirements
- R1: While rst_ni is low, res_o is 0.
- R2: res_o holds the result of the operands and controls sampled at the most recent rising edge of clk_i, and it is stable between edges.
- R3: mode_i = 0 splits each word into four 8-bit lanes, lane k at bits [8k+7:8k]. mode_i = 1 splits it into two 16-bit lanes, lane k at bits [16k+15:16k].
- R4: op_i = 0 gives a+b and op_i = 1 gives a-b in each lane, modulo 2^lane width, with no carry or borrow into the neighbouring lane.
- R5: op_i = 2 gives |a-b| per lane as an unsigned lane-width magnitude, using the order chosen by sign_i.
- R6: op_i = 3 gives (a+b+1)>>1 per lane on unsigned operands, formed with one extra bit so that the sum cannot overflow.
- R7: op_i = 4 gives the larger and op_i = 5 the smaller operand of each lane, using the order chosen by sign_i.
- R8: op_i = 6 writes 1 into a lane when the relation chosen by cmp_i holds and 0 otherwise. The codes are 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge. Codes 6 and 7 never hold.
- R9: sign_i = 1 reads the lanes as two's complement and sign_i = 0 reads them as unsigned, for compare, maximum, minimum and absolute difference. sign_i has no effect on add, subtract or average.
- R10: op_i = 7 gives 0 in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Lane split: 0 = 4x8, 1 = 2x16 |
| sign_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| op_i | input | 3 | Operation code |
| cmp_i | input | 3 | Relation used by the compare operation |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| res_o | output | 32 | Registered packed result |

## Verification
On every cycle, the assertions check properties that do not depend on exact arithmetic. Compare results must be 0/1 flags, and the reserved code must give zero. An absolute difference must be zero exactly when the operands are equal. An average must lie between its operands, and an unsigned maximum must be no smaller than either operand. Exact values need the bench's sweeps. These cover wrap-around at lane edges, freedom from carries between lanes, the rounding of the average, the choice between signed and unsigned order at the 0x80/0x8000 boundaries, and every compare code.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned CMP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 3'd1;
  localparam logic [OP_W-1:0] OP_ABSD = 3'd2;
  localparam logic [OP_W-1:0] OP_AVG  = 3'd3;
  localparam logic [OP_W-1:0] OP_MAX  = 3'd4;
  localparam logic [OP_W-1:0] OP_MIN  = 3'd5;
  localparam logic [OP_W-1:0] OP_SET  = 3'd6;
  localparam logic [OP_W-1:0] OP_NONE = 3'd7;

  localparam logic [CMP_W-1:0] CMP_EQ = 3'd0;
  localparam logic [CMP_W-1:0] CMP_NE = 3'd1;
  localparam logic [CMP_W-1:0] CMP_LT = 3'd2;
  localparam logic [CMP_W-1:0] CMP_LE = 3'd3;
  localparam logic [CMP_W-1:0] CMP_GT = 3'd4;
  localparam logic [CMP_W-1:0] CMP_GE = 3'd5;

  localparam logic MODE_NARROW = 1'b0;
  localparam logic MODE_WIDE   = 1'b1;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             sign_i,
  output logic [W-1:0]     y_o
);
  // sign- or zero-extended operands give one ordering for both modes
  logic signed [W:0]   ax, bx;
  logic signed [W+1:0] dif;
  logic [W+1:0]        dif_abs;
  logic [W:0]          avg_sum;
  logic                eq, lt, hit;

  assign ax      = $signed({sign_i & a_i[W-1], a_i});
  assign bx      = $signed({sign_i & b_i[W-1], b_i});
  assign eq      = (a_i == b_i);
  assign lt      = (ax < bx);
  assign dif     = {ax[W], ax} - {bx[W], bx};
  assign dif_abs = lt ? -dif : dif;
  assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, 1'b1};

  always_comb begin
    unique case (cmp_i)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt;
      CMP_LE:  hit = lt || eq;
      CMP_GT:  hit = !(lt || eq);
      CMP_GE:  hit = !lt;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_ABSD: y_o = dif_abs[W-1:0];
      OP_AVG:  y_o = avg_sum[W:1];
      OP_MAX:  y_o = lt ? b_i : a_i;
      OP_MIN:  y_o = lt ? a_i : b_i;
      OP_SET:  y_o = {{(W-1){1'b0}}, hit};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [CMP_W-1:0]  cmp_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .a_i    (a_i[k*LANE_W +: LANE_W]),
      .b_i    (b_i[k*LANE_W +: LANE_W]),
      .op_i   (op_i),
      .cmp_i  (cmp_i),
      .sign_i (sign_i),
      .y_o    (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/pkd_simd_alu.sv
module pkd_simd_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sign_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [CMP_W-1:0]  cmp_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NARROW_LANES = DATA_W / NARROW_W;

  logic [DATA_W-1:0] y_narrow, y_wide, y_sel;

  simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_narrow (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .cmp_i(cmp_i), .sign_i(sign_i), .y_o(y_narrow)
  );

  simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_wide (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .cmp_i(cmp_i), .sign_i(sign_i), .y_o(y_wide)
  );

  assign y_sel = (mode_i == MODE_WIDE) ? y_wide : y_narrow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= y_sel;
  end

  // R8
  set_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_SET && $past(mode_i) == MODE_NARROW)
      |-> (res_o[NARROW_W-1:1] == '0 && res_o[2*NARROW_W-1:NARROW_W+1] == '0
           && $countones(res_o) <= NARROW_LANES));

  // R10
  none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_NONE) |-> (res_o == '0));

  // R5
  absd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_ABSD && $past(mode_i) == MODE_NARROW)
      |-> ((res_o[NARROW_W-1:0] == '0) == ($past(a_i[NARROW_W-1:0]) == $past(b_i[NARROW_W-1:0]))));

  // R6
  avg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_AVG && $past(mode_i) == MODE_NARROW)
      |-> ((res_o[NARROW_W-1:0] >= $past(a_i[NARROW_W-1:0]) || res_o[NARROW_W-1:0] >= $past(b_i[NARROW_W-1:0]))
        && (res_o[NARROW_W-1:0] <= $past(a_i[NARROW_W-1:0]) || res_o[NARROW_W-1:0] <= $past(b_i[NARROW_W-1:0]))));

  // R7
  umax_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_MAX && !$past(sign_i) && $past(mode_i) == MODE_WIDE)
      |-> (res_o[WIDE_W-1:0] >= $past(a_i[WIDE_W-1:0]) && res_o[WIDE_W-1:0] >= $past(b_i[WIDE_W-1:0])));
endmodule

// File: tb/pkd_simd_alu_tb.sv
module pkd_simd_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [2:0]  cmp_i = 3'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] res_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  pkd_simd_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .sign_i(sign_i),
    .op_i(op_i), .cmp_i(cmp_i), .a_i(a_i), .b_i(b_i), .res_o(res_o)
  );

  function automatic int sval(int w, int u, bit sgn);
    if (sgn && u[w-1]) return u - (1 << w);
    return u;
  endfunction

  function automatic int ref_lane(int w, int ua, int ub, int op, int cmp, bit sgn);
    int mask = (1 << w) - 1;
    int sa = sval(w, ua, sgn & (op != 0) & (op != 1) & (op != 3));
    int sb = sval(w, ub, sgn & (op != 0) & (op != 1) & (op != 3));
    int d;
    bit h;
    case (op)
      0: return (ua + ub) & mask;
      1: return (ua - ub) & mask;
      2: begin d = sa - sb; if (d < 0) d = -d; return d & mask; end
      3: return (ua + ub + 1) >> 1;
      4: return (sa >= sb) ? ua : ub;
      5: return (sa <= sb) ? ua : ub;
      6: begin
        case (cmp)
          0: h = (sa == sb);
          1: h = (sa != sb);
          2: h = (sa < sb);
          3: h = (sa <= sb);
          4: h = (sa > sb);
          5: h = (sa >= sb);
          default: h = 1'b0;
        endcase
        return int'(h);
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R4";
      2:    return "R5";
      3:    return "R6";
      4, 5: return "R7";
      6:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h (mode %0d sign %0d op %0d cmp %0d)",
               req, act, exp, mode_i, sign_i, op_i, cmp_i);
    end
  endtask

  // drive at a negedge, register loads at next posedge, sample at the negedge after
  task automatic run_vec(bit md, bit sg, int op, int cmp, logic [31:0] a, logic [31:0] b, string req);
    int w = md ? 16 : 8;
    int lanes = 32 / w;
    logic [31:0] exp = '0;
    for (int k = 0; k < lanes; k++) begin
      int ua = int'(a >> (k * w)) & ((1 << w) - 1);
      int ub = int'(b >> (k * w)) & ((1 << w) - 1);
      exp = exp | (32'(ref_lane(w, ua, ub, op, cmp, sg)) << (k * w));
    end
    mode_i = md; sign_i = sg; op_i = 3'(op); cmp_i = 3'(cmp); a_i = a; b_i = b;
    @(negedge clk_i);
    check(req, res_o, exp);
  endtask

  localparam int NC = 8;
  int c8  [NC] = '{'h00, 'h01, 'h7f, 'h80, 'h81, 'hfe, 'hff, 'h55};
  int c16 [NC] = '{'h0000, 'h0001, 'h7fff, 'h8000, 'h8001, 'hfffe, 'hffff, 'h12ab};

  task automatic sweep(bit md, bit sg, int op, int cmp, string req);
    for (int p = 0; p < NC * NC; p++) begin
      logic [31:0] a = '0, b = '0;
      if (md) begin
        for (int k = 0; k < 2; k++) begin
          int q = (p + k * 27) % (NC * NC);
          a[16*k +: 16] = 16'(c16[q / NC]);
          b[16*k +: 16] = 16'(c16[q % NC]);
        end
      end else begin
        for (int k = 0; k < 4; k++) begin
          int q = (p + k * 17) % (NC * NC);
          a[8*k +: 8] = 8'(c8[q / NC]);
          b[8*k +: 8] = 8'(c8[q % NC]);
        end
      end
      run_vec(md, sg, op, cmp, a, b, req);
    end
  endtask

  initial begin
    #1;
    // R1: reset value while reset is held
    a_i = 32'hffff_ffff; b_i = 32'h0000_0001;
    @(negedge clk_i);
    check("R1", res_o, 32'h0);
    @(negedge clk_i);
    check("R1", res_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: output keeps the previous result until the next rising edge
    run_vec(1'b0, 1'b0, 0, 0, 32'h0102_0304, 32'h1010_1010, "R2");
    a_i = 32'h5555_5555; b_i = 32'h0;
    #1;
    check("R2", res_o, 32'h1112_1314);
    @(negedge clk_i);
    check("R2", res_o, 32'h5555_5555);

    // R3 R4: lane split changes carry boundaries
    run_vec(1'b0, 1'b0, 0, 0, 32'h00ff_00ff, 32'h0001_0001, "R3");
    check("R3", res_o, 32'h0000_0000);
    run_vec(1'b1, 1'b0, 0, 0, 32'h00ff_00ff, 32'h0001_0001, "R3");
    check("R3", res_o, 32'h0100_0100);

    // R9: sign mode distinguishes 0x80 vs 0x7f, and leaves add/avg alone
    run_vec(1'b0, 1'b1, 4, 0, 32'h8080_8080, 32'h7f7f_7f7f, "R9");
    check("R9", res_o, 32'h7f7f_7f7f);
    run_vec(1'b0, 1'b0, 4, 0, 32'h8080_8080, 32'h7f7f_7f7f, "R9");
    check("R9", res_o, 32'h8080_8080);
    run_vec(1'b0, 1'b1, 3, 0, 32'hff01_80ff, 32'h0001_80fe, "R9");
    check("R9", res_o, 32'h8001_80ff);

    // sweeps over corner values in both splits and both sign modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int op = 0; op < 8; op++) begin
          if (op == 6) begin
            for (int c = 0; c < 8; c++) sweep(m[0], s[0], op, c, "R8");
          end else begin
            sweep(m[0], s[0], op, 0, (op == 0 || op == 1 || op == 3) && s == 1 ? "R9" : tag_of(op));
          end
        end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule